// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page mappings so that a memory request can be translated without walking the page table. A 32-bit virtual address is split into a 20-bit virtual page number and a 12-bit page offset. The page number is compared against every stored entry at once. On a hit, the stored 18-bit physical page number is joined with the unchanged offset to give a 30-bit physical address. Each stored entry also carries a write-permission bit, a dirty bit and a reference bit.

A request is answered one clock after it is presented. The answer is exactly one of three outcomes: hit, miss or write-protection fault. On a miss the block pulses a request toward an external page-table walker, carrying the missing page number. The walker later returns the mapping through a refill port. The refill goes into the entry that already holds that page. If no entry holds it, it goes into the lowest-index empty entry, and failing that into the lowest-index entry whose reference bit is clear. A single flush input empties the whole cache in one cycle.

Top module: `fa_tlb`

## Requirements
- R1: After synchronous reset, all response outputs are 0 and every entry is invalid, so the first lookup of any page misses.
- R2: A lookup that hits returns resp_hit=1 on the following cycle, with resp_paddr = {stored physical page number, req_vaddr[11:0]}. The page number sits in bits 29:12 and the offset in bits 11:0.
- R3: In the cycle after an accepted lookup, exactly one of resp_hit, resp_miss and resp_fault is 1. In any other cycle all three are 0.
- R4: A write lookup that matches an entry whose write-permission bit is 0 gives resp_fault=1, resp_hit=0 and resp_paddr=0. The entry's dirty and reference bits are left unchanged.
- R5: A lookup that matches no valid entry gives resp_miss=1 and walk_req=1 on the following cycle, with walk_vpn equal to req_vaddr[31:12].
- R6: A permitted write hit sets the entry's dirty bit. resp_first_write is 1 only on a write hit that found the dirty bit clear, and is 0 otherwise.
- R7: Each entry has one reference bit, which a hit or a refill sets. Whenever the bits would all become 1, every reference bit is cleared instead.
- R8: A refill is placed in a fixed order of preference: the entry already holding fill_vpn; else the lowest-index invalid entry; else the lowest-index entry whose reference bit is clear. A page is therefore never held twice.
- R9: flush clears every valid bit and every reference bit in one cycle. A refill or lookup presented in the same cycle is ignored.
- R10: When fill_en and req_en are both 1 (without flush), the refill is performed and the lookup is dropped with no response.
- R11: A refilled entry stores fill_ppn and fill_wr_ok, and its dirty bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_en | input | 1 | Lookup request this cycle |
| req_write | input | 1 | Lookup is a store access |
| req_vaddr | input | 32 | Virtual address: page number in 31:12, offset in 11:0 |
| fill_en | input | 1 | Refill from the walker this cycle |
| fill_vpn | input | 20 | Virtual page number being refilled |
| fill_ppn | input | 18 | Physical page number for that page |
| fill_wr_ok | input | 1 | Page may be written |
| flush | input | 1 | Invalidate every entry |
| resp_hit | output | 1 | Translation delivered |
| resp_miss | output | 1 | No entry matched |
| resp_fault | output | 1 | Store to a write-protected page |
| resp_first_write | output | 1 | Write hit found the dirty bit clear |
| resp_paddr | output | 30 | Physical address, 0 unless resp_hit |
| walk_req | output | 1 | Ask the walker for a mapping |
| walk_vpn | output | 20 | Page number the walker should fetch |

## Verification
The checks that look one cycle back take for granted that req_vaddr and req_write are known whenever req_en is high, and that reset is applied before the first request. They also assume a page-table walker that answers a miss with a single-cycle fill_en pulse. The stimulus drives every input half a cycle away from the sampling edge. Refills always carry page numbers the bench's own page-table function defines. Collisions of refill, flush and lookup are produced only in deliberate directed cycles, so each priority rule is seen in isolation as well as mixed into the random traffic.

// File: rtl/fa_tlb_pkg.sv
package fa_tlb_pkg;
  localparam int DEF_ENTRIES = 16;
  localparam int DEF_VPN_W   = 20;
  localparam int DEF_PPN_W   = 18;
  localparam int DEF_OFF_W   = 12;

  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_HIT   = 2'd1,
    OUT_MISS  = 2'd2,
    OUT_FAULT = 2'd3
  } tlb_outcome_e;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int N     = 16,
  parameter int KEY_W = 20,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] key,
  input  logic [N-1:0]     valid_vec,
  input  logic [KEY_W-1:0] tags [N],
  output logic             match_hit,
  output logic [IDX_W-1:0] match_idx
);
  logic [N-1:0] match_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (tags[g] == key);
  end

  always_comb begin
    match_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) match_idx = IDX_W'(i);
    end
  end

  assign match_hit = |match_vec;

  // R8: refill placement keeps every page in at most one entry
  a_r8_single_match: assert property (@(posedge clk) disable iff (rst)
    $countones(match_vec) <= 1);
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     ref_vec,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] empty_idx, cold_idx;
  logic             any_empty;

  always_comb begin
    empty_idx = '0;
    cold_idx  = '0;
    any_empty = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        empty_idx = IDX_W'(i);
        any_empty = 1'b1;
      end
      if (!ref_vec[i]) cold_idx = IDX_W'(i);
    end
    victim_idx = any_empty ? empty_idx : cold_idx;
  end
endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
  import fa_tlb_pkg::*;
#(
  parameter int N_ENTRIES = DEF_ENTRIES,
  parameter int VPN_W     = DEF_VPN_W,
  parameter int PPN_W     = DEF_PPN_W,
  parameter int OFF_W     = DEF_OFF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_en,
  input  logic                     req_write,
  input  logic [VPN_W+OFF_W-1:0]   req_vaddr,
  input  logic                     fill_en,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [PPN_W-1:0]         fill_ppn,
  input  logic                     fill_wr_ok,
  input  logic                     flush,
  output logic                     resp_hit,
  output logic                     resp_miss,
  output logic                     resp_fault,
  output logic                     resp_first_write,
  output logic [PPN_W+OFF_W-1:0]   resp_paddr,
  output logic                     walk_req,
  output logic [VPN_W-1:0]         walk_vpn
);
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int IDX_W = $clog2(N_ENTRIES);

  // entry payload: plain arrays without reset, written only on refill
  logic [VPN_W-1:0] tag_mem [N_ENTRIES];
  logic [PPN_W-1:0] ppn_mem [N_ENTRIES];
  logic             wok_mem [N_ENTRIES];

  // per-entry state bits that need reset or bulk clear
  logic [N_ENTRIES-1:0] valid_q, ref_q, dirty_q;

  logic [VPN_W-1:0] req_vpn;
  logic             lk_hit, fl_hit;
  logic [IDX_W-1:0] lk_idx, fl_idx, victim_idx, fill_idx;
  logic             do_fill, do_look;
  tlb_outcome_e     outcome;
  logic [N_ENTRIES-1:0] ref_set, ref_merged, ref_next;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];

  tlb_cam_match #(.N(N_ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_look_cam (
    .clk(clk), .rst(rst), .key(req_vpn), .valid_vec(valid_q), .tags(tag_mem),
    .match_hit(lk_hit), .match_idx(lk_idx)
  );

  tlb_cam_match #(.N(N_ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_fill_cam (
    .clk(clk), .rst(rst), .key(fill_vpn), .valid_vec(valid_q), .tags(tag_mem),
    .match_hit(fl_hit), .match_idx(fl_idx)
  );

  tlb_victim_pick #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_vec(valid_q), .ref_vec(ref_q), .victim_idx(victim_idx)
  );

  // flush beats refill, refill beats lookup
  assign do_fill  = fill_en && !flush;
  assign do_look  = req_en && !flush && !fill_en;
  assign fill_idx = fl_hit ? fl_idx : victim_idx;

  always_comb begin
    outcome = OUT_NONE;
    if (do_look) begin
      if (!lk_hit)                           outcome = OUT_MISS;
      else if (req_write && !wok_mem[lk_idx]) outcome = OUT_FAULT;
      else                                   outcome = OUT_HIT;
    end
  end

  always_comb begin
    ref_set = '0;
    if (do_fill)                 ref_set[fill_idx] = 1'b1;
    else if (outcome == OUT_HIT) ref_set[lk_idx]   = 1'b1;
    ref_merged = ref_q | ref_set;
    ref_next   = (&ref_merged) ? '0 : ref_merged;
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_mem[fill_idx] <= fill_vpn;
      ppn_mem[fill_idx] <= fill_ppn;
      wok_mem[fill_idx] <= fill_wr_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
      ref_q   <= '0;
    end else begin
      ref_q <= ref_next;
      if (do_fill) begin
        valid_q[fill_idx] <= 1'b1;
        dirty_q[fill_idx] <= 1'b0;
      end else if (outcome == OUT_HIT && req_write) begin
        dirty_q[lk_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_hit         <= 1'b0;
      resp_miss        <= 1'b0;
      resp_fault       <= 1'b0;
      resp_first_write <= 1'b0;
      resp_paddr       <= '0;
      walk_req         <= 1'b0;
      walk_vpn         <= '0;
    end else begin
      resp_hit         <= (outcome == OUT_HIT);
      resp_miss        <= (outcome == OUT_MISS);
      resp_fault       <= (outcome == OUT_FAULT);
      resp_first_write <= (outcome == OUT_HIT) && req_write && !dirty_q[lk_idx];
      resp_paddr       <= (outcome == OUT_HIT) ? {ppn_mem[lk_idx], req_vaddr[OFF_W-1:0]} : '0;
      walk_req         <= (outcome == OUT_MISS);
      if (outcome == OUT_MISS) walk_vpn <= req_vpn;
    end
  end

  // R2: offset bits travel unchanged into the physical address
  a_r2_offset_passthru: assert property (@(posedge clk) disable iff (rst)
    resp_hit |-> resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  // R3: at most one outcome per cycle
  a_r3_single_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resp_hit, resp_miss, resp_fault}));

  // R4: a protection fault delivers no address
  a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (rst)
    resp_fault |-> (resp_paddr == '0) && !resp_first_write);

  // R5: a miss is accompanied by a walker request for the same page
  a_r5_walk_on_miss: assert property (@(posedge clk) disable iff (rst)
    resp_miss |-> walk_req && (walk_vpn == $past(req_vpn)));

  // R6: first-write flag only on a store that hit
  a_r6_first_write_on_store: assert property (@(posedge clk) disable iff (rst)
    resp_first_write |-> resp_hit && $past(req_write));

  // R7: reference bits are never all set after an update
  a_r7_ref_not_saturated: assert property (@(posedge clk) disable iff (rst)
    !(&ref_q));

  // R9: flush empties the array and suppresses any response
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0) && !resp_hit && !resp_miss && !resp_fault);

  // R10: a refill cycle produces no lookup response
  a_r10_fill_wins: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> !resp_hit && !resp_miss && !resp_fault);
endmodule

// File: tb/fa_tlb_test.sv
module fa_tlb_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_en = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        fill_en = 1'b0, fill_wr_ok = 1'b0, flush = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [17:0] fill_ppn = '0;
  logic        resp_hit, resp_miss, resp_fault, resp_first_write, walk_req;
  logic [29:0] resp_paddr;
  logic [19:0] walk_vpn;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit last_miss;

  // bench-side model of the table
  bit          mv [N];
  bit          mref [N];
  bit          mdirty [N];
  bit          mwok [N];
  logic [19:0] mtag [N];
  logic [17:0] mppn [N];

  fa_tlb uut (
    .clk(clk), .rst(rst), .req_en(req_en), .req_write(req_write), .req_vaddr(req_vaddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_wr_ok(fill_wr_ok),
    .flush(flush), .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_fault(resp_fault),
    .resp_first_write(resp_first_write), .resp_paddr(resp_paddr),
    .walk_req(walk_req), .walk_vpn(walk_vpn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [17:0] pt_ppn(input logic [19:0] vpn);
    return 18'((vpn * 37 + 5) ^ 20'h2A5A5);
  endfunction

  function automatic bit pt_wok(input logic [19:0] vpn);
    return (vpn % 3) != 0;
  endfunction

  function automatic logic [19:0] pool_vpn(input int k);
    return 20'h40000 + 20'(k * 19);
  endfunction

  function automatic int find(input logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (mv[i] && mtag[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int victim();
    for (int i = 0; i < N; i++) if (!mv[i]) return i;
    for (int i = 0; i < N; i++) if (!mref[i]) return i;
    return 0;
  endfunction

  task automatic norm_ref();
    bit all;
    all = 1'b1;
    for (int i = 0; i < N; i++) if (!mref[i]) all = 1'b0;
    if (all) for (int i = 0; i < N; i++) mref[i] = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit rq, input bit wr, input logic [31:0] va,
                      input bit fl, input logic [19:0] fv, input bit fs, input string ctx);
    bit e_hit, e_miss, e_fault, e_fw;
    logic [29:0] e_pa;
    logic [19:0] e_wv;
    int idx;
    e_hit = 0; e_miss = 0; e_fault = 0; e_fw = 0; e_pa = '0; e_wv = '0;
    if (fs) begin
      for (int i = 0; i < N; i++) begin mv[i] = 0; mref[i] = 0; end
    end else if (fl) begin
      idx = find(fv);
      if (idx < 0) idx = victim();
      mv[idx] = 1; mtag[idx] = fv; mppn[idx] = pt_ppn(fv); mwok[idx] = pt_wok(fv);
      mdirty[idx] = 0; mref[idx] = 1;
      norm_ref();
    end else if (rq) begin
      idx = find(va[31:12]);
      if (idx < 0) begin
        e_miss = 1; e_wv = va[31:12];
      end else if (wr && !mwok[idx]) begin
        e_fault = 1;
      end else begin
        e_hit = 1;
        e_pa = {mppn[idx], va[11:0]};
        e_fw = wr && !mdirty[idx];
        if (wr) mdirty[idx] = 1;
        mref[idx] = 1;
        norm_ref();
      end
    end
    req_en = rq; req_write = wr; req_vaddr = va;
    fill_en = fl; fill_vpn = fv; fill_ppn = pt_ppn(fv); fill_wr_ok = pt_wok(fv);
    flush = fs;
    @(posedge clk);
    @(negedge clk);
    req_en = 0; fill_en = 0; flush = 0;
    chk(resp_hit == e_hit, {ctx, " R2/R3 resp_hit"}, resp_hit, e_hit);
    chk(resp_miss == e_miss, {ctx, " R3/R5 resp_miss"}, resp_miss, e_miss);
    chk(resp_fault == e_fault, {ctx, " R4 resp_fault"}, resp_fault, e_fault);
    chk(resp_paddr == e_pa, {ctx, " R2 resp_paddr"}, resp_paddr, e_pa);
    chk(resp_first_write == e_fw, {ctx, " R6 resp_first_write"}, resp_first_write, e_fw);
    chk(walk_req == e_miss, {ctx, " R5 walk_req"}, walk_req, e_miss);
    if (e_miss) chk(walk_vpn == e_wv, {ctx, " R5 walk_vpn"}, walk_vpn, e_wv);
    last_miss = e_miss;
  endtask

  task automatic look(input bit wr, input logic [19:0] vpn, input string ctx);
    step(1, wr, {vpn, 12'($urandom)}, 0, '0, 0, ctx);
  endtask

  task automatic refill(input logic [19:0] vpn, input string ctx);
    step(0, 0, '0, 1, vpn, 0, ctx);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] a, b, v;
    void'($urandom(32'd20250611));
    for (int i = 0; i < N; i++) begin mv[i] = 0; mref[i] = 0; mdirty[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk({resp_hit, resp_miss, resp_fault, resp_first_write, walk_req} == 5'b0,
        "R1 reset outputs", {resp_hit, resp_miss, resp_fault, resp_first_write, walk_req}, 0);
    chk(resp_paddr == '0, "R1 reset paddr", resp_paddr, 0);

    a = 20'h12341;  // a % 3 != 0: writable
    b = 20'h12342;  // b % 3 == 0: write-protected
    look(0, a, "R1 first lookup misses");
    refill(a, "R11 refill a");
    look(0, a, "R2 read hit a");
    look(1, a, "R6 first write a");
    look(1, a, "R6 second write a");
    refill(b, "R11 refill protected b");
    look(1, b, "R4 write to protected b");
    look(0, b, "R4 read of protected b");
    refill(a, "R8 refill existing a");
    look(1, a, "R11 dirty cleared on refill");
    step(1, 0, {b, 12'h abc}, 1, 20'h55555, 0, "R10 fill over request");
    look(0, 20'h55555, "R10 refill took effect");
    step(0, 0, '0, 1, 20'h66666, 1, "R9 flush with fill");
    look(0, 20'h66666, "R9 fill ignored in flush");
    look(0, a, "R9 flushed entry misses");

    // R7 R8: deterministic replacement sequence
    step(0, 0, '0, 0, '0, 1, "R9 flush");
    for (int k = 0; k < N; k++) refill(pool_vpn(k), "R8 fill empty slots");
    for (int k = 0; k < 8; k++) look(0, pool_vpn(k), "R7 touch low half");
    refill(20'h77777, "R8 replace first cold entry");
    look(0, pool_vpn(8), "R7 R8 cold entry evicted");
    look(0, pool_vpn(9), "R8 neighbour kept");
    look(0, pool_vpn(0), "R7 referenced entry kept");

    // random traffic with a small page pool to force replacement
    for (int it = 0; it < 3000; it++) begin
      int r;
      r = $urandom % 1000;
      v = pool_vpn($urandom % 24);
      if (r < 6) begin
        step(0, 0, '0, 0, '0, 1, "R9 random flush");
      end else if (r < 20) begin
        step(1, $urandom % 2, {v, 12'($urandom)}, 1, pool_vpn($urandom % 24), 0,
             "R10 random collision");
      end else begin
        look($urandom % 2, v, "R2 random lookup");
        if (last_miss) begin
          if ($urandom % 4 == 0) step(0, 0, '0, 0, '0, 0, "R3 idle cycle");
          refill(v, "R8 random refill");
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule